// File: doc/BRIEF.md
# Pipeline Halt Controller with One-Shot Release

This block sits beside a five-stage in-order pipeline and manages a halt instruction once that instruction reaches the decode stage. In the same cycle the halt is seen, it freezes the program counter and keeps the halt word in decode. On every cycle while the halt is held, it also inserts a no-op into execute. Instructions already past decode keep flowing and drain out of the later stages. While the halt is parked, an 8-bit status word shows that the machine is halted, together with the low part of the halt code.

An external enable level, already debounced elsewhere, is turned into a single-cycle release pulse. Only a low-to-high change of enable that is observed while the halt is parked counts. One such change lets the halt leave decode exactly once. After that, enable must go low again before it can release anything.

The controller has three named states:
- `ST_RUN`: normal flow.
- `ST_PARKED`: the halt is held in decode.
- `ST_EXIT`: the single cycle in which the released halt moves on.

The transitions between them are:
- `ST_RUN` goes to `ST_PARKED` when a valid halt is decoded.
- `ST_PARKED` goes to `ST_EXIT` on a release pulse.
- `ST_EXIT` goes to `ST_RUN` unconditionally.

Top module: `halt_release_ctl`

## Requirements
- R1: In `ST_RUN`, a cycle with `id_valid`=1 and `id_is_halt`=1 drives `pc_hold`, `id_hold` and `ex_bubble` to 1 in that same cycle.
- R2: `stat` is 0 whenever the controller is not parked. From the cycle after a halt is detected, and for as long as it stays parked, `stat[7]` is 1 and `stat[6:0]` equals bits 12:6 of the halt word (the low 7 bits of the code field that spans bits 25:6). Code bits 25:13 do not appear.
- R3: While parked, all three hold outputs stay at 1 on every cycle, so only bubbles enter execute, until a release occurs.
- R4: If, while parked, `release_en` is 1 in a cycle after having been 0 in the previous cycle, the holds remain 1 in that cycle. The next cycle is the exit cycle: the holds are 0 and `stat` is 0, and a halt flag still present in decode is disregarded. Normal detection resumes in the cycle after that.
- R5: Keeping `release_en` high gives one release only. A later halt stays parked until `release_en` has been 0 for at least one cycle and then 1 again.
- R6: A rise of `release_en` that happens in the detection cycle of a halt, or earlier, does not release that halt.
- R7: Asynchronous active-low reset `rst_n` returns the controller to `ST_RUN`, clears the enable tracker and the captured code, and drives `stat` and all hold outputs to 0.
- R8: With `id_valid`=0, or `id_is_halt`=0, the hold outputs stay 0 in `ST_RUN`.
- R9: Changes of `release_en` while no halt is parked have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_valid | input | 1 | Decode stage holds a valid instruction |
| id_is_halt | input | 1 | The decode-stage instruction is a halt |
| id_instr | input | 32 | Instruction word in decode |
| release_en | input | 1 | Debounced enable level used for release |
| pc_hold | output | 1 | Stop the program counter from advancing |
| id_hold | output | 1 | Keep the decode-stage register unchanged |
| ex_bubble | output | 1 | Insert a no-op into the execute stage |
| stat | output | 8 | Halt status: {halted, code[6:0]} or 0 |

## Verification
A controller stuck in `ST_PARKED` shows all three holds high and a nonzero `stat` in the very next cycle. A controller that never parked shows a zero `stat` one cycle after detection. An enable tracker that is out of step shows up as a release one cycle early or late, or as a second release without enable going low in between. A corrupted code register appears at once in `stat[6:0]`. The scoreboard compares the holds and `stat` on every cycle. Because of that, any of these faults is reported in the cycle it first appears.

// File: rtl/halt_rel_pkg.sv
package halt_rel_pkg;

    // Controller states
    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_PARKED = 2'd1,
        ST_EXIT   = 2'd2
    } hr_state_e;

endpackage

// File: rtl/hr_edge_pulse.sv
// Turns a level into a pulse on its rising edge; the level must fall
// before another pulse can occur.
module hr_edge_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    output logic pulse
);
    logic level_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level_in;
    end

    assign pulse = level_in & ~level_q;
endmodule

// File: rtl/hr_fsm.sv
module hr_fsm
    import halt_rel_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      halt_seen,
    input  logic      release_pulse,
    output hr_state_e state,
    output logic      hold_all,
    output logic      capture,
    output logic      parked
);
    hr_state_e state_nxt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nxt;
    end

    // Transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_RUN:    if (halt_seen)     state_nxt = ST_PARKED;
            ST_PARKED: if (release_pulse) state_nxt = ST_EXIT;
            ST_EXIT:                      state_nxt = ST_RUN;
            default:                      state_nxt = ST_RUN;
        endcase
    end

    // Outputs
    always_comb begin
        hold_all = 1'b0;
        capture  = 1'b0;
        parked   = 1'b0;
        unique case (state)
            ST_RUN: begin
                hold_all = halt_seen;
                capture  = halt_seen;
            end
            ST_PARKED: begin
                hold_all = 1'b1;
                parked   = 1'b1;
            end
            ST_EXIT: begin
                hold_all = 1'b0;
            end
            default: begin
                hold_all = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/hr_status.sv
module hr_status #(
    parameter int STAT_W   = 8,
    parameter int CODE_LSB = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              show,
    input  logic [STAT_W-2:0] code_in,
    output logic [STAT_W-1:0] stat
);
    localparam int SHOWN_W = STAT_W - 1;

    logic [SHOWN_W-1:0] code_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       code_q <= '0;
        else if (capture) code_q <= code_in;
    end

    assign stat = show ? {1'b1, code_q} : '0;

    // Field position kept for documentation of the slice the parent takes.
    localparam int FIELD_LSB = CODE_LSB;
    logic unused_field_lsb;
    assign unused_field_lsb = (FIELD_LSB < 0);
endmodule

// File: rtl/halt_release_ctl.sv
module halt_release_ctl
    import halt_rel_pkg::*;
#(
    parameter int INSTR_W  = 32,
    parameter int STAT_W   = 8,
    parameter int CODE_LSB = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               id_valid,
    input  logic               id_is_halt,
    input  logic [INSTR_W-1:0] id_instr,
    input  logic               release_en,
    output logic               pc_hold,
    output logic               id_hold,
    output logic               ex_bubble,
    output logic [STAT_W-1:0]  stat
);
    localparam int SHOWN_W = STAT_W - 1;
    localparam int SHOWN_MSB = CODE_LSB + SHOWN_W - 1;

    hr_state_e state;
    logic      halt_seen;
    logic      rel_pulse;
    logic      hold_all;
    logic      capture;
    logic      parked;

    assign halt_seen = id_valid & id_is_halt;

    hr_edge_pulse u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_in (release_en),
        .pulse    (rel_pulse)
    );

    hr_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .halt_seen     (halt_seen),
        .release_pulse (rel_pulse),
        .state         (state),
        .hold_all      (hold_all),
        .capture       (capture),
        .parked        (parked)
    );

    hr_status #(
        .STAT_W   (STAT_W),
        .CODE_LSB (CODE_LSB)
    ) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .show    (parked),
        .code_in (id_instr[SHOWN_MSB:CODE_LSB]),
        .stat    (stat)
    );

    assign pc_hold   = hold_all;
    assign id_hold   = hold_all;
    assign ex_bubble = hold_all;

    logic unused_instr_bits;
    assign unused_instr_bits = ^{id_instr[INSTR_W-1:SHOWN_MSB+1],
                                 id_instr[CODE_LSB-1:0], state};
endmodule

// File: rtl/halt_release_ctl_chk.sv
module halt_release_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       release_en,
    input logic       pc_hold,
    input logic       id_hold,
    input logic       ex_bubble,
    input logic [7:0] stat
);
    // R2
    stat_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[7]) |-> $past(pc_hold));

    // R3
    parked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat[7] |-> (pc_hold && id_hold && ex_bubble));

    // R2
    stat_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat[7] && $past(stat[7])) |-> $stable(stat));

    // R4
    exit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat[7]) |-> (!pc_hold && !id_hold && !ex_bubble));

    // R5
    release_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat[7]) |-> ($past(release_en) && !$past(release_en, 2)));
endmodule

bind halt_release_ctl halt_release_ctl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .release_en (release_en),
    .pc_hold    (pc_hold),
    .id_hold    (id_hold),
    .ex_bubble  (ex_bubble),
    .stat       (stat)
);

// File: tb/halt_release_ctl_tb.sv
`timescale 1ns/1ps
module halt_release_ctl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        id_valid = 1'b0;
    logic        id_is_halt = 1'b0;
    logic [31:0] id_instr = '0;
    logic        release_en = 1'b0;
    logic        pc_hold, id_hold, ex_bubble;
    logic [7:0]  stat;

    always #2.5 clk = ~clk;

    halt_release_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_is_halt(id_is_halt),
        .id_instr(id_instr), .release_en(release_en), .pc_hold(pc_hold),
        .id_hold(id_hold), .ex_bubble(ex_bubble), .stat(stat)
    );

    typedef struct {
        logic [2:0] hold;
        logic [7:0] stat;
        string      tag;
    } exp_t;

    exp_t sb_q[$];
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;

    function automatic logic [31:0] mk(input logic [6:0] lo, input logic [12:0] hi);
        return {6'h00, hi, lo, 6'h0D};
    endfunction

    task automatic cyc(input logic v, input logic h, input logic [31:0] ins,
                       input logic en, input logic hold, input logic [7:0] st,
                       input string tag);
        exp_t e;
        @(negedge clk);
        rst_n = 1'b1; id_valid = v; id_is_halt = h; id_instr = ins; release_en = en;
        e.hold = {3{hold}}; e.stat = st; e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic rst_cycle(input string tag);
        exp_t e;
        @(negedge clk);
        rst_n = 1'b0; id_valid = 1'b0; id_is_halt = 1'b0; id_instr = '0; release_en = 1'b0;
        e.hold = 3'b000; e.stat = 8'h00; e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: compares each cycle's outputs against the queued expectation
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                checks++;
                if ({pc_hold, id_hold, ex_bubble} !== e.hold || stat !== e.stat) begin
                    fails++;
                    $display("FAIL %s holds=%b stat=%h expected holds=%b stat=%h",
                             e.tag, {pc_hold, id_hold, ex_bubble}, stat, e.hold, e.stat);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] nop_w, h1, h2, h3;
        nop_w = 32'h0000_0021;
        h1 = mk(7'h5A, 13'h0000);
        h2 = mk(7'h00, 13'h0001);
        h3 = mk(7'h7F, 13'h1555);

        // R7 reset state
        rst_cycle("R7"); rst_cycle("R7"); rst_cycle("R7");

        // R8 no valid halt, R9 enable activity while running
        cyc(1, 0, nop_w, 0, 0, 8'h00, "R8");
        cyc(0, 1, h1,    0, 0, 8'h00, "R8");
        cyc(1, 0, nop_w, 1, 0, 8'h00, "R9");
        cyc(1, 0, nop_w, 0, 0, 8'h00, "R9");
        cyc(1, 0, nop_w, 1, 0, 8'h00, "R9");
        cyc(1, 0, nop_w, 0, 0, 8'h00, "R9");

        // R1..R4 basic park and release
        cyc(1, 1, h1,    0, 1, 8'h00, "R1");
        cyc(1, 1, h1,    0, 1, 8'hDA, "R2");
        cyc(1, 1, h1,    0, 1, 8'hDA, "R3");
        cyc(1, 1, h1,    1, 1, 8'hDA, "R4");
        cyc(1, 1, h1,    1, 0, 8'h00, "R4");
        cyc(1, 0, nop_w, 1, 0, 8'h00, "R4");

        // R5 enable still high: next halt parks until low then high
        cyc(1, 1, h2,    1, 1, 8'h00, "R5");
        cyc(1, 1, h2,    1, 1, 8'h80, "R2");
        cyc(1, 1, h2,    1, 1, 8'h80, "R5");
        cyc(1, 1, h2,    1, 1, 8'h80, "R5");
        cyc(1, 1, h2,    0, 1, 8'h80, "R5");
        cyc(1, 1, h2,    1, 1, 8'h80, "R5");
        cyc(1, 1, h2,    1, 0, 8'h00, "R4");
        cyc(1, 0, nop_w, 1, 0, 8'h00, "R5");

        // R6 enable rises in the detection cycle: no release
        cyc(1, 0, nop_w, 0, 0, 8'h00, "R6");
        cyc(1, 1, h3,    1, 1, 8'h00, "R6");
        cyc(1, 1, h3,    1, 1, 8'hFF, "R6");
        cyc(1, 1, h3,    1, 1, 8'hFF, "R6");
        cyc(1, 1, h3,    1, 1, 8'hFF, "R6");
        cyc(1, 1, h3,    0, 1, 8'hFF, "R6");
        cyc(1, 1, h3,    1, 1, 8'hFF, "R4");
        cyc(1, 1, h3,    0, 0, 8'h00, "R4");

        // R1 halt directly after an exit, then R7 reset while parked
        cyc(1, 1, h1,    0, 1, 8'h00, "R1");
        cyc(1, 1, h1,    0, 1, 8'hDA, "R2");
        rst_cycle("R7");
        rst_cycle("R7");
        cyc(1, 0, nop_w, 0, 0, 8'h00, "R7");
        cyc(1, 0, nop_w, 1, 0, 8'h00, "R9");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule